// File: doc/BRIEF.md
# Character raster timing generator

This block produces the horizontal sync, vertical sync and display-enable strobes for a character-based video raster. Three free-running counters drive them: a character counter along the line, a scanline counter inside each character row, and a character-row counter down the frame. Each counter is compared with a writable limit. A small write port lets a processor reprogram any limit at any moment, including while a count is in progress. The display fetch logic uses the enable strobe, and the monitor takes the two syncs.

The generator advances one character per clock. Each counter returns to zero only when it equals its limit exactly. Programs that rewrite limits in the middle of a frame, for split screens, short frames or frames with no sync pulse, therefore get repeatable timing, even when the values look inconsistent.

Top module: `crtc_timing_gen`

## Requirements
- R1: The character counter starts at 0 and advances by one on every clock. On the clock after it equals the line limit (address 0), it returns to 0, so a line lasts line limit + 1 clocks. The line limit defaults to 63, which gives a 64-clock line.
- R2: Every counter restarts only on exact equality. If a limit is rewritten below the counter's live value, the counter keeps counting to 255, wraps to 0, and only then can match. With a sync position of 46, lowering the line limit to 50 while the count is near 67 makes the gap between two hsync pulses exactly 256 clocks.
- R3: The scanline counter advances at each line end and wraps after it equals the scanline limit (address 7, bits 4:0, default 7). That wrap advances the row counter. The row counter returns to 0 after it equals the row limit (address 4, default 38). No extra adjust lines are added, so a frame is (row limit+1)·(scanline limit+1)·(line limit+1) clocks.
- R4: de is high only for character counts below the visible width (address 1, default 40) on rows below the visible height (address 5, default 25). Once a count equals its visible value, de stays low for the rest of that line, or for the rest of that frame.
- R5: If the visible height exceeds the row limit, de never goes low for vertical reasons, so every row is visible.
- R6: hsync rises when the character count equals the hsync position (address 2, default 46). It then lasts the number of clocks given in address 3 bits 3:0 (default 14). A width of 0 produces no pulse.
- R7: vsync rises at the start of scanline 0 of the row equal to the vsync position (address 6, default 30). It then lasts the number of scanlines given in address 3 bits 7:4 (default 8).
- R8: If the row limit is below the vsync position, no vsync pulse appears, and the counters and hsync keep running.
- R9: A write on the clock edge where wr_en is high takes effect in the next clock. Writes to addresses 8 to 15 change nothing.
- R10: While rst is high, de, hsync and vsync are low and all limits return to their defaults. Each output shows the counter state one clock after that state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Character clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe for the limit registers |
| wr_addr | input | 4 | Register address |
| wr_data | input | 8 | Write data |
| de | output | 1 | Display enable |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |

## Verification
The bench lowers the line limit below the live count and expects the following hsync gap to stretch to 256 clocks. A design that compared with greater-or-equal would restart early and give a short gap. It sets a row limit below the vsync position and expects no vsync while hsync continues; a design that clamped or stalled would either emit vsync or freeze. It sets the visible height above the row limit and checks that de covers every row. It gives the hsync width as zero and writes unused addresses, which catches designs that emit a one-clock pulse or alias the upper addresses onto real registers. Throughout, a cycle-by-cycle reference compares all three outputs.

// File: rtl/crtc_pkg.sv
package crtc_pkg;
  localparam int CNT_W    = 8;
  localparam int RAS_W    = 5;
  localparam int SW_W     = 4;
  localparam int DATA_W   = 8;
  localparam int NUM_REGS = 8;
  localparam int IDX_W    = $clog2(NUM_REGS);

  typedef enum logic [IDX_W-1:0] {
    RG_LINE_LIM  = 3'd0,
    RG_VIS_W     = 3'd1,
    RG_HS_POS    = 3'd2,
    RG_SYNC_W    = 3'd3,
    RG_ROW_LIM   = 3'd4,
    RG_VIS_H     = 3'd5,
    RG_VS_POS    = 3'd6,
    RG_SCAN_LIM  = 3'd7
  } reg_idx_e;

  typedef struct packed {
    logic [CNT_W-1:0] htot;
    logic [CNT_W-1:0] hdisp;
    logic [CNT_W-1:0] hspos;
    logic [SW_W-1:0]  vsw;
    logic [SW_W-1:0]  hsw;
    logic [CNT_W-1:0] vtot;
    logic [CNT_W-1:0] vdisp;
    logic [CNT_W-1:0] vspos;
    logic [RAS_W-1:0] maxras;
  } crtc_cfg_t;
endpackage

// File: rtl/crtc_regfile.sv
module crtc_regfile
  import crtc_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int DEF_HTOT   = 63,
  parameter int DEF_HDISP  = 40,
  parameter int DEF_HSPOS  = 46,
  parameter int DEF_HSW    = 14,
  parameter int DEF_VSW    = 8,
  parameter int DEF_VTOT   = 38,
  parameter int DEF_VDISP  = 25,
  parameter int DEF_VSPOS  = 30,
  parameter int DEF_MAXRAS = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output crtc_cfg_t         cfg
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(NUM_REGS - 1);

  logic     addr_ok;
  reg_idx_e idx;

  assign addr_ok = wr_en && (wr_addr <= LAST_ADDR);
  assign idx     = reg_idx_e'(wr_addr[IDX_W-1:0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg.htot   <= CNT_W'(DEF_HTOT);
      cfg.hdisp  <= CNT_W'(DEF_HDISP);
      cfg.hspos  <= CNT_W'(DEF_HSPOS);
      cfg.hsw    <= SW_W'(DEF_HSW);
      cfg.vsw    <= SW_W'(DEF_VSW);
      cfg.vtot   <= CNT_W'(DEF_VTOT);
      cfg.vdisp  <= CNT_W'(DEF_VDISP);
      cfg.vspos  <= CNT_W'(DEF_VSPOS);
      cfg.maxras <= RAS_W'(DEF_MAXRAS);
    end else if (addr_ok) begin
      case (idx)
        RG_LINE_LIM: cfg.htot   <= wr_data[CNT_W-1:0];
        RG_VIS_W:    cfg.hdisp  <= wr_data[CNT_W-1:0];
        RG_HS_POS:   cfg.hspos  <= wr_data[CNT_W-1:0];
        RG_SYNC_W: begin
          cfg.hsw <= wr_data[SW_W-1:0];
          cfg.vsw <= wr_data[2*SW_W-1:SW_W];
        end
        RG_ROW_LIM:  cfg.vtot   <= wr_data[CNT_W-1:0];
        RG_VIS_H:    cfg.vdisp  <= wr_data[CNT_W-1:0];
        RG_VS_POS:   cfg.vspos  <= wr_data[CNT_W-1:0];
        RG_SCAN_LIM: cfg.maxras <= wr_data[RAS_W-1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/crtc_pulse.sv
module crtc_pulse #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  input  logic         start,
  input  logic [W-1:0] width,
  output logic         active
);
  logic [W-1:0] left_q;

  assign active = (start && (width != '0)) || (left_q != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q <= '0;
    end else if (step) begin
      if (start)
        left_q <= (width == '0) ? '0 : width - W'(1);
      else if (left_q != '0)
        left_q <= left_q - W'(1);
    end
  end
endmodule

// File: rtl/crtc_hgen.sv
module crtc_hgen
  import crtc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] htot,
  input  logic [CNT_W-1:0] hdisp,
  input  logic [CNT_W-1:0] hspos,
  input  logic [SW_W-1:0]  hsw,
  output logic [CNT_W-1:0] hcnt,
  output logic             line_end,
  output logic             h_active,
  output logic             hs_now
);
  logic hen_q;

  assign line_end = (hcnt == htot);
  assign h_active = hen_q && (hcnt != hdisp);

  always_ff @(posedge clk) begin
    if (rst) begin
      hcnt  <= '0;
      hen_q <= 1'b1;
    end else begin
      hcnt  <= line_end ? '0 : hcnt + CNT_W'(1);
      hen_q <= line_end ? 1'b1 : h_active;
    end
  end

  crtc_pulse #(.W(SW_W)) u_hs (
    .clk    (clk),
    .rst    (rst),
    .step   (1'b1),
    .start  (hcnt == hspos),
    .width  (hsw),
    .active (hs_now)
  );
endmodule

// File: rtl/crtc_vgen.sv
module crtc_vgen
  import crtc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             line_end,
  input  logic [CNT_W-1:0] vtot,
  input  logic [CNT_W-1:0] vdisp,
  input  logic [CNT_W-1:0] vspos,
  input  logic [SW_W-1:0]  vsw,
  input  logic [RAS_W-1:0] maxras,
  output logic [RAS_W-1:0] ras,
  output logic [CNT_W-1:0] row,
  output logic             v_active,
  output logic             vs_now
);
  logic ven_q;
  logic row_end;
  logic frame_end;
  logic vs_start;

  assign row_end   = line_end && (ras == maxras);
  assign frame_end = row_end && (row == vtot);
  assign v_active  = ven_q && (row != vdisp);
  assign vs_start  = (row == vspos) && (ras == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      ras   <= '0;
      row   <= '0;
      ven_q <= 1'b1;
    end else begin
      if (line_end)
        ras <= (ras == maxras) ? '0 : ras + RAS_W'(1);
      if (row_end) begin
        row   <= frame_end ? '0 : row + CNT_W'(1);
        ven_q <= frame_end ? 1'b1 : v_active;
      end
    end
  end

  crtc_pulse #(.W(SW_W)) u_vs (
    .clk    (clk),
    .rst    (rst),
    .step   (line_end),
    .start  (vs_start),
    .width  (vsw),
    .active (vs_now)
  );
endmodule

// File: rtl/crtc_timing_gen.sv
module crtc_timing_gen
  import crtc_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              de,
  output logic              hsync,
  output logic              vsync
);
  crtc_cfg_t        cfg;
  logic [CNT_W-1:0] hcnt;
  logic [CNT_W-1:0] row;
  logic [RAS_W-1:0] ras;
  logic             line_end;
  logic             h_active;
  logic             v_active;
  logic             hs_now;
  logic             vs_now;

  crtc_regfile #(.ADDR_W(ADDR_W)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .cfg     (cfg)
  );

  crtc_hgen u_h (
    .clk      (clk),
    .rst      (rst),
    .htot     (cfg.htot),
    .hdisp    (cfg.hdisp),
    .hspos    (cfg.hspos),
    .hsw      (cfg.hsw),
    .hcnt     (hcnt),
    .line_end (line_end),
    .h_active (h_active),
    .hs_now   (hs_now)
  );

  crtc_vgen u_v (
    .clk      (clk),
    .rst      (rst),
    .line_end (line_end),
    .vtot     (cfg.vtot),
    .vdisp    (cfg.vdisp),
    .vspos    (cfg.vspos),
    .vsw      (cfg.vsw),
    .maxras   (cfg.maxras),
    .ras      (ras),
    .row      (row),
    .v_active (v_active),
    .vs_now   (vs_now)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      de    <= 1'b0;
      hsync <= 1'b0;
      vsync <= 1'b0;
    end else begin
      de    <= h_active && v_active;
      hsync <= hs_now;
      vsync <= vs_now;
    end
  end
endmodule

// File: rtl/crtc_timing_chk.sv
module crtc_timing_chk
  import crtc_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input crtc_cfg_t         cfg,
  input logic [CNT_W-1:0]  hcnt,
  input logic [CNT_W-1:0]  row,
  input logic [RAS_W-1:0]  ras,
  input logic              line_end,
  input logic              de,
  input logic              hsync,
  input logic              vsync
);
  localparam logic [ADDR_W-1:0] FIRST_BAD = ADDR_W'(NUM_REGS);

  p_line_restart_r1: assert property (@(posedge clk) disable iff (rst)
    (hcnt == cfg.htot) |=> (hcnt == '0));

  p_step_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    (hcnt != cfg.htot) |=> (hcnt == CNT_W'($past(hcnt) + CNT_W'(1))));

  p_row_step_r3: assert property (@(posedge clk) disable iff (rst)
    (line_end && (ras == cfg.maxras) && (row != cfg.vtot)) |=>
      (row == CNT_W'($past(row) + CNT_W'(1))) && (ras == '0));

  p_frame_restart_r3: assert property (@(posedge clk) disable iff (rst)
    (line_end && (ras == cfg.maxras) && (row == cfg.vtot)) |=>
      (row == '0) && (ras == '0));

  p_de_border_r4: assert property (@(posedge clk) disable iff (rst)
    de |-> $past((hcnt != cfg.hdisp) && (row != cfg.vdisp)));

  p_hs_start_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(hsync) |-> $past(hcnt == cfg.hspos));

  p_vs_start_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(vsync) |-> $past((row == cfg.vspos) && (ras == '0)));

  p_bad_addr_r9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (wr_addr >= FIRST_BAD)) |=> $stable(cfg));
endmodule

bind crtc_timing_gen crtc_timing_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .wr_en    (wr_en),
  .wr_addr  (wr_addr),
  .cfg      (cfg),
  .hcnt     (hcnt),
  .row      (row),
  .ras      (ras),
  .line_end (line_end),
  .de       (de),
  .hsync    (hsync),
  .vsync    (vsync)
);

// File: tb/crtc_timing_gen_tb.sv
`timescale 1ns/1ps
module crtc_timing_gen_tb;
  logic       clk = 1'b0;
  logic       rst;
  logic       wr_en;
  logic [3:0] wr_addr;
  logic [7:0] wr_data;
  logic       de, hsync, vsync;

  always #4 clk = ~clk;

  crtc_timing_gen u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .de(de), .hsync(hsync), .vsync(vsync)
  );

  int    n_checks = 0;
  int    n_err    = 0;
  bit    done     = 1'b0;
  string phase    = "R10";

  logic [2:0] exp_q[$];

  // reference model state
  logic [7:0] m_htot, m_hdisp, m_hspos, m_vtot, m_vdisp, m_vspos;
  logic [3:0] m_hsw, m_vsw, m_hl, m_vl;
  logic [4:0] m_maxras, m_ras;
  logic [7:0] m_h, m_row;
  logic       m_hen, m_ven;

  always @(posedge clk) begin
    logic le, ha, va, hsn, vsn, vst, re, fe;
    if (rst) begin
      m_htot = 8'd63; m_hdisp = 8'd40; m_hspos = 8'd46;
      m_hsw = 4'd14; m_vsw = 4'd8;
      m_vtot = 8'd38; m_vdisp = 8'd25; m_vspos = 8'd30; m_maxras = 5'd7;
      m_h = 8'd0; m_row = 8'd0; m_ras = 5'd0;
      m_hen = 1'b1; m_ven = 1'b1; m_hl = 4'd0; m_vl = 4'd0;
      exp_q.push_back(3'b000);
    end else begin
      le  = (m_h == m_htot);
      ha  = m_hen && (m_h != m_hdisp);
      va  = m_ven && (m_row != m_vdisp);
      hsn = ((m_h == m_hspos) && (m_hsw != 4'd0)) || (m_hl != 4'd0);
      vst = (m_row == m_vspos) && (m_ras == 5'd0);
      vsn = (vst && (m_vsw != 4'd0)) || (m_vl != 4'd0);
      exp_q.push_back({ha && va, hsn, vsn});
      re = le && (m_ras == m_maxras);
      fe = re && (m_row == m_vtot);
      if (m_h == m_hspos) m_hl = (m_hsw == 4'd0) ? 4'd0 : m_hsw - 4'd1;
      else if (m_hl != 4'd0) m_hl = m_hl - 4'd1;
      if (le) begin
        if (vst) m_vl = (m_vsw == 4'd0) ? 4'd0 : m_vsw - 4'd1;
        else if (m_vl != 4'd0) m_vl = m_vl - 4'd1;
      end
      m_hen = le ? 1'b1 : ha;
      if (re) m_ven = fe ? 1'b1 : va;
      m_h = le ? 8'd0 : m_h + 8'd1;
      if (le) m_ras = (m_ras == m_maxras) ? 5'd0 : m_ras + 5'd1;
      if (re) m_row = fe ? 8'd0 : m_row + 8'd1;
      if (wr_en && wr_addr < 4'd8) begin
        case (wr_addr[2:0])
          3'd0: m_htot  = wr_data;
          3'd1: m_hdisp = wr_data;
          3'd2: m_hspos = wr_data;
          3'd3: begin m_hsw = wr_data[3:0]; m_vsw = wr_data[7:4]; end
          3'd4: m_vtot  = wr_data;
          3'd5: m_vdisp = wr_data;
          3'd6: m_vspos = wr_data;
          default: m_maxras = wr_data[4:0];
        endcase
      end
    end
  end

  // monitor: scoreboard compare and frame statistics
  int   cyc = 0, hs_rise_t = 0, vs_rise_t = 0;
  int   hs_per_last = 0, vs_per_last = 0;
  int   de_cnt = 0, hs_cnt = 0, vs_cnt = 0, de_last = 0, hs_last = 0, vs_last = 0;
  int   hs_rises = 0, vs_rises = 0;
  logic hs_prev = 1'b0, vs_prev = 1'b0;

  always @(negedge clk) begin
    logic [2:0] e;
    logic [2:0] a;
    if (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      a = {de, hsync, vsync};
      n_checks++;
      if (a !== e) begin
        n_err++;
        $display("FAIL %s de/hsync/vsync actual %b expected %b at cycle %0d", phase, a, e, cyc);
      end
    end
    if (!rst) begin
      cyc++;
      if (hsync && !hs_prev) begin
        hs_per_last = cyc - hs_rise_t; hs_rise_t = cyc; hs_rises++;
      end
      if (vsync && !vs_prev) begin
        vs_per_last = cyc - vs_rise_t; vs_rise_t = cyc; vs_rises++;
        de_last = de_cnt; hs_last = hs_cnt; vs_last = vs_cnt;
        de_cnt = 0; hs_cnt = 0; vs_cnt = 0;
      end
      de_cnt += int'(de); hs_cnt += int'(hsync); vs_cnt += int'(vsync);
    end
    hs_prev = hsync;
    vs_prev = vsync;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp_v);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp_v);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_vs(input int n);
    int s;
    s = vs_rises;
    wait (vs_rises >= s + n);
    @(negedge clk);
  endtask

  task automatic wait_hs(input int n);
    int s;
    s = hs_rises;
    wait (hs_rises >= s + n);
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_err++;
      $display("FAIL watchdog actual running expected finished");
      finish_run();
    end
  end

  initial begin
    int r0, h0;
    rst = 1'b1; wr_en = 1'b0; wr_addr = 4'd0; wr_data = 8'd0;
    repeat (5) @(negedge clk);
    // R10: outputs low in reset
    chk(!de && !hsync && !vsync, "R10", int'({de, hsync, vsync}), 0);
    rst = 1'b0;

    // default timing: R1, R3, R4, R6, R7
    phase = "R1";
    wait_vs(2);
    chk(hs_per_last == 64, "R1", hs_per_last, 64);
    chk(vs_per_last == 19968, "R3", vs_per_last, 19968);
    chk(de_last == 8000, "R4", de_last, 8000);
    chk(hs_last == 4368, "R6", hs_last, 4368);
    chk(vs_last == 512, "R7", vs_last, 512);

    // R2: lowered limit runs to wrap before matching
    phase = "R2";
    wr(4'd0, 8'd200);
    wait_hs(1);
    repeat (20) @(negedge clk);
    wr(4'd0, 8'd50);
    wait_hs(1);
    chk(hs_per_last == 256, "R2", hs_per_last, 256);

    // small frame: 10 clocks/line, 3 lines/row, 5 rows
    phase = "R3";
    wr(4'd0, 8'd9);  wr(4'd1, 8'd6);  wr(4'd2, 8'd7);  wr(4'd3, 8'h32);
    wr(4'd4, 8'd4);  wr(4'd5, 8'd3);  wr(4'd6, 8'd2);  wr(4'd7, 8'd2);
    wait_vs(3);
    chk(hs_per_last == 10, "R1", hs_per_last, 10);
    chk(vs_per_last == 150, "R3", vs_per_last, 150);
    chk(de_last == 54, "R4", de_last, 54);
    chk(hs_last == 30, "R6", hs_last, 30);
    chk(vs_last == 30, "R7", vs_last, 30);

    // R5: visible height beyond row limit
    phase = "R5";
    wr(4'd5, 8'd10);
    wait_vs(2);
    chk(de_last == 90, "R5", de_last, 90);

    // R6: zero hsync width
    phase = "R6";
    wr(4'd3, 8'h30);
    wait_vs(2);
    chk(hs_last == 0, "R6", hs_last, 0);
    wr(4'd3, 8'h32);

    // R9: upper addresses ignored
    phase = "R9";
    wr(4'd8, 8'd0);
    wr(4'd15, 8'd0);
    wr(4'd12, 8'd1);
    wait_vs(2);
    chk(vs_per_last == 150, "R9", vs_per_last, 150);
    chk(hs_per_last == 10, "R9", hs_per_last, 10);

    // R8: row limit below vsync position
    phase = "R8";
    wr(4'd4, 8'd1);
    wr(4'd6, 8'd3);
    repeat (10000) @(negedge clk);
    r0 = vs_rises; h0 = hs_rises;
    repeat (2000) @(negedge clk);
    chk(vs_rises == r0, "R8", vs_rises - r0, 0);
    chk(hs_rises - h0 == 200, "R8", hs_rises - h0, 200);

    done = 1'b1;
    finish_run();
  end
endmodule